// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a slave on a two-wire serial bus (clock line and open-drain data line) that lets a bus master read and write a bank of 8-bit control registers held inside the block. Both bus lines are sampled by the system clock through two-flop synchronisers. Start, repeated-start and stop conditions are found by comparing successive synchronised samples. The block answers to one 7-bit device address, whose lowest bit is taken from a select pin, so two copies can share one bus.

A write transaction carries the device address byte, then a register base address byte, then any number of data bytes. Each data byte is stored at the current register pointer, and a one-cycle strobe with its address and value is given to the surrounding logic. The pointer then steps up by one, but it stops at the top register address. A read transaction always begins at the base address stored by the most recent write transaction. The master can therefore set the base and then issue a repeated start to read. The data line is never driven high: the block only asserts a drive-low enable.

Top module: `i2c_regport`

## Requirements
- R1: A falling data line while the clock line is high (start) returns the block to the device-address phase from any state, including in the middle of a transfer. A rising data line while the clock line is high (stop) returns it to idle with the data line released. A byte clocked after a stop and without a new start is neither acknowledged nor stored.
- R2: The device address is 7'b1001_10s, where s is the `addr_sel` pin. It is sent MSB first and followed by a direction bit (1 = read, 0 = write). When the address matches, the block pulls the data line low for the whole ninth clock pulse.
- R3: When the device address does not match, the block gives no acknowledge, stores nothing and does not drive the data line until the next start.
- R4: In a write, the second byte is the base address. Every later byte is acknowledged, written to the register at the pointer, and announced by a one-cycle `wr_strobe` carrying `wr_addr` and `wr_data`. The pointer then advances by one.
- R5: When the pointer is at TOP_ADDR (default 8'h3F), further written bytes all go to TOP_ADDR. In a read, bytes after the one at TOP_ADDR repeat the TOP_ADDR register.
- R6: A base address above TOP_ADDR is not acknowledged. The stored base is left unchanged. The bytes that follow, up to the next start or stop, are neither acknowledged nor stored.
- R7: A read sends register bytes MSB first, starting at the base address from the most recent write transaction, and advances the pointer after each byte.
- R8: A master NACK on the ninth clock of a read byte ends the data. The block then drives nothing until the next start or stop, so further clock pulses read all ones.
- R9: A repeated start after a base address write switches to a read that begins at that base.
- R10: The drive-low enable only ever becomes active while the clock line is low.
- R11: After reset the data line is released, `wr_strobe` is low, all registers read zero and the stored base address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| addr_sel | input | 1 | Lowest bit of the device address |
| sda_drive_low | output | 1 | When high, the pad pulls the data line low |
| wr_strobe | output | 1 | One-cycle pulse for each register written by the bus |
| wr_addr | output | 8 | Register address of the current write strobe |
| wr_data | output | 8 | Data value of the current write strobe |

## Verification
The assertions check on every cycle these properties:
- the drive-low enable never rises while the synchronised clock line is high;
- a start or stop resets the phase and releases the line;
- the ignore state stays silent;
- each write strobe lasts one cycle and addresses a register within range;
- a write at the top address leaves the pointer there.

Only the bench scenarios can show the values that are read back and the acknowledge pattern seen by a master across whole transactions. This covers the base address carried from a write into a later read, saturation on reads, a rejected base address leaving the old base in place, and the all-ones line after a master NACK.

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [7:0] TOP_ADDR = 8'h3F,
  parameter logic [5:0] DEV_HI   = 6'b100110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       addr_sel,
  output logic       sda_drive_low,
  output logic       wr_strobe,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);

  localparam int DEPTH = int'(TOP_ADDR) + 1;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_WR, S_RD, S_SKIP} state_t;

  logic       scl_m, scl_s, scl_q;
  logic       sda_m, sda_s, sda_q;
  state_t     state, nxt;
  logic [3:0] cnt;
  logic       in_ack;
  logic [7:0] shreg, tx, ptr, base;
  logic [7:0] regs [0:DEPTH-1];

  wire start    = scl_s & scl_q & sda_q & ~sda_s;
  wire stop     = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire match    = (shreg[7:1] == {DEV_HI, addr_sel});
  wire [7:0] ptr_next = (ptr == TOP_ADDR) ? ptr : ptr + 8'd1;
  wire [7:0] rd_byte  = regs[ptr[AW-1:0]];
  wire [7:0] base_rd  = regs[base[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q} <= 3'b111;
      {sda_m, sda_s, sda_q} <= 3'b111;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      nxt           <= S_IDLE;
      cnt           <= '0;
      in_ack        <= 1'b0;
      shreg         <= '0;
      tx            <= '0;
      ptr           <= '0;
      base          <= '0;
      sda_drive_low <= 1'b0;
      wr_strobe     <= 1'b0;
      wr_addr       <= '0;
      wr_data       <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      wr_strobe <= 1'b0;
      if (start) begin
        state <= S_DEV;
        cnt <= '0;
        in_ack <= 1'b0;
        sda_drive_low <= 1'b0;
      end else if (stop) begin
        state <= S_IDLE;
        cnt <= '0;
        in_ack <= 1'b0;
        sda_drive_low <= 1'b0;
      end else if (state != S_IDLE && state != S_SKIP) begin
        if (scl_rise) begin
          if (!in_ack) begin
            if (cnt < 4'd8) begin
              cnt   <= cnt + 4'd1;
              shreg <= {shreg[6:0], sda_s};
              tx    <= {tx[6:0], 1'b0};
            end
          end else if (state == S_RD && sda_s) begin
            nxt <= S_SKIP;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= '0;
            state  <= nxt;
            if (nxt == S_RD) begin
              tx            <= rd_byte;
              sda_drive_low <= ~rd_byte[7];
            end else begin
              sda_drive_low <= 1'b0;
            end
          end else if (cnt == 4'd8) begin
            in_ack <= 1'b1;
            case (state)
              S_DEV: begin
                if (match) begin
                  sda_drive_low <= 1'b1;
                  nxt <= shreg[0] ? S_RD : S_REG;
                  if (shreg[0]) ptr <= base;
                end else begin
                  state  <= S_SKIP;
                  in_ack <= 1'b0;
                end
              end
              S_REG: begin
                if (shreg <= TOP_ADDR) begin
                  sda_drive_low <= 1'b1;
                  base <= shreg;
                  ptr  <= shreg;
                  nxt  <= S_WR;
                end else begin
                  state  <= S_SKIP;
                  in_ack <= 1'b0;
                end
              end
              S_WR: begin
                sda_drive_low <= 1'b1;
                regs[ptr[AW-1:0]] <= shreg;
                wr_strobe <= 1'b1;
                wr_addr   <= ptr;
                wr_data   <= shreg;
                ptr <= ptr_next;
                nxt <= S_WR;
              end
              S_RD: begin
                sda_drive_low <= 1'b0;
                ptr <= ptr_next;
                nxt <= S_RD;
              end
              default: begin
                state  <= S_SKIP;
                in_ack <= 1'b0;
              end
            endcase
          end else if (state == S_RD) begin
            sda_drive_low <= ~tx[7];
          end
        end
      end
    end
  end

  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_s) |=> !$rose(sda_drive_low));

  p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == S_DEV && !sda_drive_low));

  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state == S_IDLE && !sda_drive_low));

  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> (!sda_drive_low && !wr_strobe));

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  p_sat_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && wr_addr == TOP_ADDR) |-> (ptr == TOP_ADDR));

  p_strobe_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_addr <= TOP_ADDR));

  p_base_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (base <= TOP_ADDR) && (base_rd == regs[base[AW-1:0]]));

endmodule

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  wire  sda_drive_low;
  wire  wr_strobe;
  wire [7:0] wr_addr, wr_data;
  wire  sda_bus = sda_m & ~sda_drive_low;

  int nchk = 0;
  int nfail = 0;
  int nstb = 0;
  int ndrv = 0;
  int viol = 0;
  logic prev_drv = 1'b0;
  logic [7:0] log_a [0:15];
  logic [7:0] log_d [0:15];

  // each entry: {addr_sel, base, data0, data1}
  localparam logic [24:0] VEC [4] = '{
    {1'b0, 8'h00, 8'hA5, 8'h5A},
    {1'b1, 8'h10, 8'h3C, 8'hC3},
    {1'b0, 8'h20, 8'hFF, 8'h01},
    {1'b1, 8'h3E, 8'h77, 8'h88}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regport uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .addr_sel(addr_sel), .sda_drive_low(sda_drive_low),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    prev_drv <= sda_drive_low;
    if (sda_drive_low) ndrv <= ndrv + 1;
    if (sda_drive_low && !prev_drv && scl_m) viol <= viol + 1;
    if (wr_strobe) begin
      log_a[nstb[3:0]] <= wr_addr;
      log_d[nstb[3:0]] <= wr_data;
      nstb <= nstb + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); acked = !sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); b[i] = sda_bus; qw(); scl_m = 1'b0;
    end
    qw(); sda_m = !give_ack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  task automatic run_all();
    bit a0, a1, a2, a3;
    logic [7:0] b0, b1;
    int n0, d0;

    repeat (5) @(negedge clk);
    check(!sda_drive_low && !wr_strobe, "R11 reset outputs", {sda_drive_low, wr_strobe}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: read from reset base 0 gives zero
    bus_start(); send_byte(8'h99, a0); recv_byte(b0, 1'b0); bus_stop();
    check(a0, "R2 read address ack after reset", a0, 1);
    check(b0 == 8'h00, "R11 register zero after reset", b0, 0);

    foreach (VEC[k]) begin
      addr_sel = VEC[k][24];
      n0 = nstb;
      bus_start();
      send_byte({6'b100110, VEC[k][24], 1'b0}, a0);
      send_byte(VEC[k][23:16], a1);
      send_byte(VEC[k][15:8], a2);
      send_byte(VEC[k][7:0], a3);
      bus_stop();
      check(a0 && a1 && a2 && a3, "R4 write bytes acknowledged", {a0, a1, a2, a3}, 4'hF);
      check(nstb - n0 == 2, "R4 strobe count", nstb - n0, 2);
      check(log_a[n0[3:0]] == VEC[k][23:16] && log_d[n0[3:0]] == VEC[k][15:8],
            "R4 first strobe addr/data", {log_a[n0[3:0]], log_d[n0[3:0]]}, {VEC[k][23:16], VEC[k][15:8]});
      check(log_a[4'(n0 + 1)] == VEC[k][23:16] + 8'd1 && log_d[4'(n0 + 1)] == VEC[k][7:0],
            "R4 second strobe addr/data", {log_a[4'(n0 + 1)], log_d[4'(n0 + 1)]},
            {VEC[k][23:16] + 8'd1, VEC[k][7:0]});
      bus_start();
      send_byte({6'b100110, VEC[k][24], 1'b1}, a0);
      recv_byte(b0, 1'b1);
      recv_byte(b1, 1'b0);
      bus_stop();
      check(a0, "R2 read address ack", a0, 1);
      check(b0 == VEC[k][15:8] && b1 == VEC[k][7:0], "R7 read from base", {b0, b1},
            {VEC[k][15:8], VEC[k][7:0]});
    end

    // R3: wrong address (select bit mismatch)
    addr_sel = 1'b0;
    n0 = nstb; d0 = ndrv;
    bus_start(); send_byte(8'h9A, a0); send_byte(8'h05, a1); send_byte(8'hEE, a2); bus_stop();
    check(!a0 && !a1 && !a2, "R3 mismatch no acknowledge", {a0, a1, a2}, 0);
    check(nstb == n0 && ndrv == d0, "R3 mismatch silent", nstb - n0 + ndrv - d0, 0);

    // R5: saturation at top address
    n0 = nstb;
    bus_start(); send_byte(8'h98, a0); send_byte(8'h3F, a1);
    send_byte(8'h11, a2); send_byte(8'h22, a3); send_byte(8'h33, a3); bus_stop();
    check(a1 && a2 && a3 && nstb - n0 == 3, "R5 top writes acked", nstb - n0, 3);
    check(log_a[4'(n0 + 2)] == 8'h3F && log_a[4'(n0 + 1)] == 8'h3F && log_d[4'(n0 + 2)] == 8'h33,
          "R5 writes stay at top", {log_a[4'(n0 + 2)], log_d[4'(n0 + 2)]}, 16'h3F33);
    bus_start(); send_byte(8'h99, a0); recv_byte(b0, 1'b1); recv_byte(b1, 1'b0); bus_stop();
    check(b0 == 8'h33 && b1 == 8'h33, "R5 read repeats top", {b0, b1}, 16'h3333);

    // R6: base above top rejected
    n0 = nstb;
    bus_start(); send_byte(8'h98, a0); send_byte(8'h40, a1); send_byte(8'hAB, a2); bus_stop();
    check(a0 && !a1 && !a2, "R6 high base nacked", {a0, a1, a2}, 3'b100);
    check(nstb == n0, "R6 no strobe after high base", nstb - n0, 0);
    bus_start(); send_byte(8'h99, a0); recv_byte(b0, 1'b0); bus_stop();
    check(b0 == 8'h33, "R6 base kept at 3F", b0, 8'h33);

    // R9: repeated start from write to read
    bus_start(); send_byte(8'h98, a0); send_byte(8'h10, a1);
    bus_start(); send_byte(8'h99, a2); recv_byte(b0, 1'b1); recv_byte(b1, 1'b0); bus_stop();
    check(a1 && a2, "R9 repeated start acks", {a1, a2}, 2'b11);
    check(b0 == 8'h3C && b1 == 8'hC3, "R9 read after repeated start", {b0, b1}, 16'h3CC3);

    // R8: master NACK ends data
    bus_start(); send_byte(8'h99, a0); recv_byte(b0, 1'b0);
    d0 = ndrv;
    recv_byte(b1, 1'b0);
    bus_stop();
    check(b0 == 8'h3C, "R8 byte before nack", b0, 8'h3C);
    check(b1 == 8'hFF && ndrv == d0, "R8 released after nack", b1, 8'hFF);

    // R1: byte after stop without start ignored
    n0 = nstb;
    bus_start(); send_byte(8'h98, a0); send_byte(8'h00, a1); bus_stop();
    qw(); scl_m = 1'b0; qw();
    send_byte(8'h99, a2); send_byte(8'h44, a3);
    scl_m = 1'b1; qw(); qw();
    check(!a2 && !a3 && nstb == n0, "R1 bytes after stop ignored", {a2, a3}, 0);
    check(!sda_drive_low, "R1 line released when idle", sda_drive_low, 0);

    // R1: start in the middle of a byte returns to the address phase
    n0 = nstb;
    bus_start(); send_byte(8'h98, a0); send_byte(8'h00, a1);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
    bus_start(); send_byte(8'h99, a2); recv_byte(b0, 1'b0); bus_stop();
    check(a2 && nstb == n0, "R1 start mid-byte resets phase", {a2, nstb - n0}, 1);
    check(b0 == 8'hA5, "R1 read after mid-byte start", b0, 8'hA5);

    check(viol == 0, "R10 drive rose while clock high", viol, 0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule